// File: doc/BRIEF.md
# Hashed Page Table Lookup Engine

The engine translates a virtual page number for one process into a physical page number by searching a hashed page table held in memory. No radix walk is involved. A lookup is accepted together with the table base address. The engine hashes the page number with the process identifier to pick a 64-byte slot of eight 8-byte entries. It then reads those entries one at a time until it finds a valid entry whose page number and process identifier both equal the request.

When all eight entries of the first slot fail to match, the engine moves to a second slot chosen by an alternate hash and scans it the same way. Both slots are searched in hardware. If neither slot holds the translation, the engine returns a miss, and software falls back to its complete backup structure. Memory is reached through a single read port with a valid/ready request channel and a data-return pulse. Each entry costs one read, so a lookup takes at most sixteen reads.

Top module: `hpt_lookup`

## Requirements
- R1: The primary slot index is the low SLOT_BITS bits of (VPN XOR zero-extended PID). The first read goes to table_base + 64 * index. table_base is sampled when the lookup is accepted.
- R2: Inside a slot, the entries are read at way 0 through 7 in ascending order, at byte offsets of 8 * way. There is one read per entry. The next read is issued only after the previous read's data has returned.
- R3: An entry matches only when all three of these hold: bit 63 (valid) is 1, bits [62:55] equal the request PID, and bits [51:32] equal the request VPN. The translation is taken from bits [19:0]. An invalid entry never matches, even when its other fields are equal.
- R4: The scan stops at the first matching entry and returns rsp_hit=1 with that entry's PPN. The number of reads equals the position of the match plus one, counting primary slot positions 0-7 and secondary slot positions 8-15.
- R5: After eight non-matching entries in the primary slot, the engine scans the secondary slot in the same order. The secondary slot index is the bitwise NOT of the primary index, kept to SLOT_BITS bits.
- R6: If no entry in either slot matches, the engine responds after exactly 16 reads with rsp_hit=0 and rsp_ppn=0.
- R7: Once mem_req_valid is raised, it stays high with a stable mem_req_addr until mem_req_ready. Once rsp_valid is raised, it stays high with stable rsp_hit and rsp_ppn until rsp_ready.
- R8: req_ready is high only while the engine is idle, so only one lookup is in flight at a time. Changes to req_vpn, req_pid and table_base after acceptance do not affect the lookup in progress.
- R9: After reset, req_ready is 1, mem_req_valid is 0 and rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| table_base | input | ADDR_W | Byte address of the hashed table, sampled when a lookup is accepted |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle and able to accept a lookup |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_pid | input | PID_W | Process identifier of the request |
| rsp_valid | output | 1 | Lookup result present |
| rsp_ready | input | 1 | Result consumed |
| rsp_hit | output | 1 | 1 when a matching entry was found |
| rsp_ppn | output | PPN_W | Physical page number of the match, 0 on a miss |
| mem_req_valid | output | 1 | Entry read request present |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | ADDR_W | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | One-cycle pulse carrying the read data |
| mem_rsp_data | input | 64 | Entry contents |

## Verification
The bench places the single true match at every one of the sixteen scan positions and also runs a full miss. The other entries are filled with decoys of four kinds: an invalid copy of the exact key, a PID that is off by one bit, a VPN that is off by one bit, and a second valid match placed after the first. A design that ignores the valid bit, compares only the VPN, or keeps scanning past the first hit returns the wrong PPN or the wrong read count. A design that gets the alternate hash wrong reads the wrong secondary addresses from position 8 onward. The hash keys are chosen to reach every slot index of a 4-bit configuration, so a mistake in masking or wrap-around shows up in the checked address sequence. Memory stalls and delayed data, together with a held response, test whether the engine holds each request and result stable.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } hpt_state_e;

  // Primary slot index: key folded with the process id, kept to nbits bits.
  function automatic logic [31:0] hash_primary(input logic [31:0] vpn,
                                               input logic [31:0] pid,
                                               input int unsigned nbits);
    logic [31:0] mask;
    mask = (32'd1 << nbits) - 32'd1;
    return (vpn ^ pid) & mask;
  endfunction

  // Secondary slot index: complement of the primary one, kept to nbits bits.
  function automatic logic [31:0] hash_alternate(input logic [31:0] prim,
                                                 input int unsigned nbits);
    logic [31:0] mask;
    mask = (32'd1 << nbits) - 32'd1;
    return (~prim) & mask;
  endfunction

endpackage

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int VPN_W     = 20,
  parameter int PID_W     = 8,
  parameter int SLOT_BITS = 10,
  parameter int WAYS      = 8,
  localparam int WAY_W    = $clog2(WAYS)
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [PID_W-1:0]  pid,
  input  logic              alt,
  input  logic [WAY_W-1:0]  way,
  output logic [ADDR_W-1:0] addr
);
  localparam int ENTRY_SHIFT = 3;                     // 8-byte entry
  localparam int SLOT_SHIFT  = WAY_W + ENTRY_SHIFT;   // WAYS entries per slot

  logic [31:0] idx_prim;
  logic [31:0] idx_alt;
  logic [31:0] idx_sel;

  assign idx_prim = hpt_pkg::hash_primary(32'(vpn), 32'(pid), SLOT_BITS);
  assign idx_alt  = hpt_pkg::hash_alternate(idx_prim, SLOT_BITS);
  assign idx_sel  = alt ? idx_alt : idx_prim;

  assign addr = base + ADDR_W'(idx_sel << SLOT_SHIFT)
              + (ADDR_W'(way) << ENTRY_SHIFT);
endmodule

// File: rtl/hpt_pte_match.sv
module hpt_pte_match #(
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  parameter int PPN_W = 20
) (
  input  logic [63:0]      pte,
  input  logic [VPN_W-1:0] vpn,
  input  logic [PID_W-1:0] pid,
  output logic             hit,
  output logic [PPN_W-1:0] ppn
);
  localparam int VLD_BIT = 63;
  localparam int PID_LSB = VLD_BIT - PID_W;
  localparam int VPN_LSB = 32;
  localparam int PPN_LSB = 0;

  logic unused_rsvd;
  assign unused_rsvd = ^{pte[PID_LSB-1:VPN_LSB+VPN_W], pte[VPN_LSB-1:PPN_LSB+PPN_W]};

  assign hit = pte[VLD_BIT]
            && (pte[PID_LSB +: PID_W] == pid)
            && (pte[VPN_LSB +: VPN_W] == vpn);
  assign ppn = pte[PPN_LSB +: PPN_W];
endmodule

// File: rtl/hpt_lookup.sv
module hpt_lookup #(
  parameter int ADDR_W    = 32,
  parameter int VPN_W     = 20,
  parameter int PID_W     = 8,
  parameter int PPN_W     = 20,
  parameter int SLOT_BITS = 10,
  parameter int WAYS      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] table_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [PID_W-1:0]  req_pid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data
);
  import hpt_pkg::*;

  localparam int WAY_W = $clog2(WAYS);
  localparam logic [WAY_W-1:0] WAY_LAST = WAY_W'(WAYS - 1);

  hpt_state_e        state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [PID_W-1:0]  pid_q;
  logic [ADDR_W-1:0] base_q;
  logic              alt_q;
  logic [WAY_W-1:0]  way_q;
  logic              hit_q;
  logic [PPN_W-1:0]  ppn_q;

  // Named events for the checker
  logic              pte_hit;
  logic [PPN_W-1:0]  pte_ppn;
  logic              slot_end;
  logic              lookup_accept;
  logic              entry_back;

  hpt_addr_gen #(
    .ADDR_W(ADDR_W), .VPN_W(VPN_W), .PID_W(PID_W),
    .SLOT_BITS(SLOT_BITS), .WAYS(WAYS)
  ) u_addr (
    .base(base_q), .vpn(vpn_q), .pid(pid_q),
    .alt(alt_q), .way(way_q), .addr(mem_req_addr)
  );

  hpt_pte_match #(
    .VPN_W(VPN_W), .PID_W(PID_W), .PPN_W(PPN_W)
  ) u_match (
    .pte(mem_rsp_data), .vpn(vpn_q), .pid(pid_q),
    .hit(pte_hit), .ppn(pte_ppn)
  );

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign rsp_valid     = (state_q == ST_DONE);
  assign rsp_hit       = hit_q;
  assign rsp_ppn       = ppn_q;

  assign lookup_accept = req_valid && req_ready;
  assign entry_back    = (state_q == ST_WAIT) && mem_rsp_valid;
  assign slot_end      = (way_q == WAY_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vpn_q   <= '0;
      pid_q   <= '0;
      base_q  <= '0;
      alt_q   <= 1'b0;
      way_q   <= '0;
      hit_q   <= 1'b0;
      ppn_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (lookup_accept) begin
            vpn_q   <= req_vpn;
            pid_q   <= req_pid;
            base_q  <= table_base;
            alt_q   <= 1'b0;
            way_q   <= '0;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (entry_back) begin
            if (pte_hit) begin
              hit_q   <= 1'b1;
              ppn_q   <= pte_ppn;
              state_q <= ST_DONE;
            end else if (!slot_end) begin
              way_q   <= way_q + WAY_W'(1);
              state_q <= ST_ISSUE;
            end else if (!alt_q) begin
              alt_q   <= 1'b1;
              way_q   <= '0;
              state_q <= ST_ISSUE;
            end else begin
              hit_q   <= 1'b0;
              ppn_q   <= '0;
              state_q <= ST_DONE;
            end
          end
        end
        ST_DONE: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpt_lookup_chk.sv
module hpt_lookup_chk #(
  parameter int ADDR_W = 32,
  parameter int PPN_W  = 20,
  parameter int WAYS   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic [PPN_W-1:0]  rsp_ppn,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              pte_hit,
  input logic              alt_q
);
  localparam int CW = $clog2(2 * WAYS) + 2;
  localparam logic [CW-1:0] MAX_RD = CW'(2 * WAYS);
  localparam logic [CW-1:0] SLOT_RD = CW'(WAYS);

  logic [CW-1:0] rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_cnt <= '0;
    else if (req_valid && req_ready) rd_cnt <= '0;
    else if (mem_req_valid && mem_req_ready) rd_cnt <= rd_cnt + CW'(1);
  end

  a_r7_memreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_ppn));

  a_r8_one_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !mem_req_valid);

  a_r6_miss_after_all: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rd_cnt == MAX_RD && rsp_ppn == '0);

  a_r4_read_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rd_cnt <= MAX_RD);

  a_r4_stop_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && pte_hit |=> rsp_valid && rsp_hit);

  a_r5_second_slot: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (alt_q == (rd_cnt >= SLOT_RD)));
endmodule

bind hpt_lookup hpt_lookup_chk #(
  .ADDR_W(ADDR_W), .PPN_W(PPN_W), .WAYS(WAYS)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .pte_hit(pte_hit), .alt_q(alt_q)
);

// File: tb/sim_hpt_lookup.sv
module sim_hpt_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int VW = 20;
  localparam int PW = 8;
  localparam int NW = 20;
  localparam int SB = 4;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] table_base;
  logic          req_valid;
  logic          req_ready;
  logic [VW-1:0] req_vpn;
  logic [PW-1:0] req_pid;
  logic          rsp_valid;
  logic          rsp_ready;
  logic          rsp_hit;
  logic [NW-1:0] rsp_ppn;
  logic          mem_req_valid;
  logic          mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid;
  logic [63:0]   mem_rsp_data;

  hpt_lookup #(
    .ADDR_W(AW), .VPN_W(VW), .PID_W(PW), .PPN_W(NW), .SLOT_BITS(SB), .WAYS(8)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .table_base(table_base),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_pid(req_pid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  int n_vec = 0;
  int n_bad = 0;
  int rd_n  = 0;
  logic [63:0]   pte_img  [16];
  logic [AW-1:0] exp_addr [16];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_pte(input logic v, input logic [PW-1:0] pid,
                                         input logic [VW-1:0] vpn, input logic [NW-1:0] ppn);
    logic [63:0] e;
    e = 64'd0;
    e[63]    = v;
    e[62:55] = pid;
    e[51:32] = vpn;
    e[19:0]  = ppn;
    return e;
  endfunction

  function automatic logic [NW-1:0] ppn_of(input logic [VW-1:0] vpn, input int k);
    return NW'(vpn * 3 + 20'(k * 17) + 20'h0A5);
  endfunction

  // Memory model: stalls ready on every third cycle, returns data 1-2 cycles later.
  initial begin
    int cyc = 0;
    int dly = 0;
    logic pend = 1'b0;
    logic [63:0] rdata = 64'd0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 64'd0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rdata;
          pend = 1'b0;
        end else dly--;
      end
      mem_req_ready = (cyc % 3) != 0;
      if (mem_req_valid && mem_req_ready) begin
        if (rd_n < 16) begin
          if (rd_n == 0)
            check(mem_req_addr == exp_addr[0], "R1", "first read address",
                  64'(mem_req_addr), 64'(exp_addr[0]));
          else if (rd_n < 8)
            check(mem_req_addr == exp_addr[rd_n], "R2", "primary slot read address",
                  64'(mem_req_addr), 64'(exp_addr[rd_n]));
          else
            check(mem_req_addr == exp_addr[rd_n], "R5", "secondary slot read address",
                  64'(mem_req_addr), 64'(exp_addr[rd_n]));
        end else begin
          check(1'b0, "R6", "read beyond sixteen", 64'(rd_n + 1), 64'd16);
        end
        rdata = 64'd0;
        for (int k = 0; k < 16; k++)
          if (exp_addr[k] == mem_req_addr) rdata = pte_img[k];
        rd_n++;
        pend = 1'b1;
        dly  = cyc % 2;
      end
    end
  end

  // p = position of the true match, 0..15; 16 means no match anywhere.
  task automatic run_lookup(input logic [VW-1:0] vpn, input logic [PW-1:0] pid,
                            input logic [AW-1:0] base, input int p);
    logic [31:0] mask;
    logic [31:0] h1;
    logic [31:0] h2;
    int waited;
    logic [NW-1:0] exp_ppn;
    logic [NW-1:0] held_ppn;
    logic held_hit;
    mask = 32'(1 << SB) - 32'd1;
    h1 = (32'(vpn) ^ 32'(pid)) & mask;
    h2 = mask - h1;
    for (int k = 0; k < 16; k++) begin
      exp_addr[k] = base + AW'(((k < 8) ? h1 : h2) * 64) + AW'((k % 8) * 8);
      if (k == p) pte_img[k] = mk_pte(1'b1, pid, vpn, ppn_of(vpn, k));
      else begin
        case ((k + p) % 4)
          0: pte_img[k] = mk_pte(1'b0, pid, vpn, ppn_of(vpn, k));
          1: pte_img[k] = mk_pte(1'b1, pid ^ 8'h01, vpn, ppn_of(vpn, k));
          2: pte_img[k] = mk_pte(1'b1, pid, vpn ^ 20'h00001, ppn_of(vpn, k));
          default:
            if (k > p) pte_img[k] = mk_pte(1'b1, pid, vpn, ppn_of(vpn, k) ^ 20'h5555);
            else       pte_img[k] = mk_pte(1'b1, pid ^ 8'h80, vpn ^ 20'h80000, ppn_of(vpn, k));
        endcase
      end
    end
    rd_n       = 0;
    table_base = base;
    req_vpn    = vpn;
    req_pid    = pid;
    req_valid  = 1'b1;
    @(negedge clk);
    check(!req_ready, "R8", "busy after accept", 64'(req_ready), 64'd0);
    req_valid  = 1'b0;
    table_base = ~base;
    req_vpn    = ~vpn;
    req_pid    = ~pid;
    waited = 0;
    while (!rsp_valid && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    if (!rsp_valid) begin
      check(1'b0, "R4", "response timeout", 64'(waited), 64'd0);
      return;
    end
    if (p < 16) begin
      exp_ppn = ppn_of(vpn, p);
      check(rsp_hit == 1'b1, "R3", "hit flag", 64'(rsp_hit), 64'd1);
      check(rsp_ppn == exp_ppn, "R4", "first match ppn", 64'(rsp_ppn), 64'(exp_ppn));
      check(rd_n == p + 1, "R4", "reads until match", 64'(rd_n), 64'(p + 1));
    end else begin
      check(rsp_hit == 1'b0, "R6", "miss flag", 64'(rsp_hit), 64'd0);
      check(rsp_ppn == '0, "R6", "miss ppn", 64'(rsp_ppn), 64'd0);
      check(rd_n == 16, "R6", "reads on miss", 64'(rd_n), 64'd16);
    end
    held_hit = rsp_hit;
    held_ppn = rsp_ppn;
    @(negedge clk);
    check(rsp_valid && rsp_hit == held_hit && rsp_ppn == held_ppn, "R7",
          "response held", 64'(rsp_ppn), 64'(held_ppn));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(req_ready && !rsp_valid, "R8", "idle after response",
          64'({req_ready, rsp_valid}), 64'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R4", "watchdog expired", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    rsp_ready  = 1'b0;
    req_vpn    = '0;
    req_pid    = '0;
    table_base = '0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R9", "req_ready in reset", 64'(req_ready), 64'd1);
    check(mem_req_valid == 1'b0, "R9", "mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rsp_valid && req_ready && !mem_req_valid, "R9", "idle after reset",
          64'({rsp_valid, req_ready, mem_req_valid}), 64'b010);
    // Every match position plus a miss, for three key sets.
    for (int p = 0; p <= 16; p++) run_lookup(20'h12345, 8'h5A, 32'h8000_0000, p);
    for (int p = 0; p <= 16; p++) run_lookup(20'hFFFFF, 8'h00, 32'h0000_1000, p);
    for (int p = 0; p <= 16; p++) run_lookup(20'h00003, 8'hFF, 32'hFFFF_FC00, p);
    // Sweep all primary slot indices of the small table.
    for (int s = 0; s < 16; s++)
      run_lookup(20'(s * 16 + 7) ^ 20'h00A30, 8'(s * 13), 32'h0004_0000, (s * 5) % 17);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule